// File: doc/BRIEF.md
# Byte-Swapping IDE Register Window Bridge

This block is a memory-mapped slave that turns host accesses on a big-endian bus into register accesses on a little-endian IDE task-file register set. The block occupies a 4096-byte window. Registers are spaced 16 bytes apart. A byte access reaches a task-file register, or the device-control / alternate-status register, which answers at two aliased indices. Halfword and word accesses reach the data port only at index 0, and the block swaps their byte lanes in both directions. Any access that maps to no register completes anyway. An unmapped read returns all ones at the access width, and an unmapped write is dropped.

The host side is a valid/ready request channel with a one-cycle-later acknowledge. A request is accepted in a cycle where `req_valid` and `req_ready` are both high. The host must hold the request fields steady while `req_ready` is low. `req_ready` is low only in the cycle that shows the acknowledge, so the sustained rate is one access every two cycles. The response has no back-pressure: `rsp_valid` pulses for one cycle. `rsp_rdata` keeps its value until the next accepted request. The downstream side is a plain register port. It carries one combinational read or write strobe together with a target select, a register number and the width. Read data is sampled in the same cycle.

Top module: `idewin_bridge`

## Requirements
- R1: Only address bits [11:0] are decoded, and the register index is address bits [11:4]. Address bits above bit 11 and bits [3:0] have no effect on routing or data.
- R2: A byte access (size code 0) at index 1 to 7 asserts the matching strobe with dn_sel = 0 (task file), dn_idx equal to the index, and dn_size = 0. Write data goes out on dn_wdata[7:0] with the upper bits zero. Read data returns in rsp_rdata[7:0] with the upper bits zero.
- R3: A byte write at index 8 or index 22 asserts dn_wr with dn_sel = 1 (control), and a byte read at either index asserts dn_rd with dn_sel = 1. This read is the alternate-status path, which clears no pending interrupt. dn_idx is 0 for this target.
- R4: A byte access at any other index, index 0 included, raises no strobe. A read of it returns 0x000000FF.
- R5: A halfword (size code 1) or word (size code 2) access at index 0 asserts the matching strobe with dn_sel = 2 (data port), dn_idx = 0 and dn_size equal to the request size. No byte access ever reaches the data port.
- R6: A halfword or word access at a nonzero index raises no strobe. A halfword read of it returns 0x0000FFFF, and a word read returns 0xFFFFFFFF.
- R7: Halfword data-port traffic has its two bytes exchanged in both directions. The upper 16 bits are zero on dn_wdata and on rsp_rdata.
- R8: Word data-port traffic has all four bytes reversed in both directions.
- R9: An accepted request gives rsp_valid high for exactly the next cycle, and req_ready is low in that cycle.
- R10: rsp_rdata changes only on the clock edge that follows an accepted request. An accepted write loads zero.
- R11: At most one of dn_rd and dn_wr is high, and only in a cycle where a request is accepted.
- R12: Size code 3 is reserved and treated as unmapped: no strobe, and a read returns 0xFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Bridge can accept a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Host byte address |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| req_wdata | input | 32 | Host write data, right-aligned |
| rsp_valid | output | 1 | One-cycle acknowledge |
| rsp_rdata | output | 32 | Read result, held until next accepted request |
| dn_rd | output | 1 | Downstream read strobe |
| dn_wr | output | 1 | Downstream write strobe |
| dn_sel | output | 2 | Target: 0 task file, 1 control, 2 data port |
| dn_idx | output | 3 | Task-file register number |
| dn_size | output | 2 | Access width code |
| dn_wdata | output | 32 | Lane-adjusted write data |
| dn_rdata | input | 32 | Downstream read data, sampled in the strobe cycle |

## Verification
The hardest case to reach is an access whose address looks plausible but maps to nothing. Examples are a byte at index 0, a halfword next to the data port, a control alias with random high address bits, and the reserved size code. A purely random address almost never lands on these. The stimulus therefore draws the index from a weighted set of boundary values: 0, 1, 7, 8, 9, 21, 22, 23 and 255. It fills the upper and lower address bits at random and mixes all four size codes. Directed accesses then cover each alias and swap pattern with distinctive byte values.

// File: rtl/idewin_pkg.sv
package idewin_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    TGT_TASKFILE = 2'd0,
    TGT_CONTROL  = 2'd1,
    TGT_DATA     = 2'd2,
    TGT_NONE     = 2'd3
  } tgt_e;

  typedef struct packed {
    tgt_e       tgt;
    logic [2:0] reg_no;
  } route_t;

endpackage

// File: rtl/idewin_decode.sv
module idewin_decode
  import idewin_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int WIN_BITS    = 12,
  parameter int STRIDE_BITS = 4,
  parameter int TF_FIRST    = 1,
  parameter int TF_LAST     = 7,
  parameter int CTRL_IDX_A  = 8,
  parameter int CTRL_IDX_B  = 22,
  parameter int DATA_IDX    = 0
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  output route_t            route
);
  localparam int IDX_W = WIN_BITS - STRIDE_BITS;

  logic [IDX_W-1:0] idx;
  logic             is_tf;
  logic             is_ctrl;
  logic             is_data;

  always_comb begin
    idx     = addr[WIN_BITS-1:STRIDE_BITS];
    is_tf   = (idx >= IDX_W'(TF_FIRST)) && (idx <= IDX_W'(TF_LAST));
    is_ctrl = (idx == IDX_W'(CTRL_IDX_A)) || (idx == IDX_W'(CTRL_IDX_B));
    is_data = (idx == IDX_W'(DATA_IDX));
    route.tgt    = TGT_NONE;
    route.reg_no = '0;
    unique case (acc_size_e'(size))
      SZ_BYTE: begin
        if (is_tf) begin
          route.tgt    = TGT_TASKFILE;
          route.reg_no = idx[2:0];
        end else if (is_ctrl) begin
          route.tgt = TGT_CONTROL;
        end
      end
      SZ_HALF, SZ_WORD: begin
        if (is_data) route.tgt = TGT_DATA;
      end
      default: route.tgt = TGT_NONE;
    endcase
  end

endmodule

// File: rtl/idewin_lanes.sv
module idewin_lanes
  import idewin_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [1:0]        size,
  input  tgt_e              tgt,
  input  logic              is_write,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic [DATA_W-1:0] dev_rdata,
  output logic [DATA_W-1:0] dev_wdata,
  output logic [DATA_W-1:0] host_rdata
);
  localparam int NB   = DATA_W / 8;
  localparam int HALF = 2;

  logic [DATA_W-1:0] wr_half_sw, wr_word_sw;
  logic [DATA_W-1:0] rd_half_sw, rd_word_sw;

  genvar lane;
  generate
    for (lane = 0; lane < NB; lane++) begin : g_word
      assign wr_word_sw[lane*8 +: 8] = host_wdata[(NB-1-lane)*8 +: 8];
      assign rd_word_sw[lane*8 +: 8] = dev_rdata[(NB-1-lane)*8 +: 8];
    end
    for (lane = 0; lane < NB; lane++) begin : g_half
      if (lane < HALF) begin : g_lo
        assign wr_half_sw[lane*8 +: 8] = host_wdata[(HALF-1-lane)*8 +: 8];
        assign rd_half_sw[lane*8 +: 8] = dev_rdata[(HALF-1-lane)*8 +: 8];
      end else begin : g_hi
        assign wr_half_sw[lane*8 +: 8] = 8'h00;
        assign rd_half_sw[lane*8 +: 8] = 8'h00;
      end
    end
  endgenerate

  always_comb begin
    unique case (acc_size_e'(size))
      SZ_HALF: dev_wdata = wr_half_sw;
      SZ_WORD: dev_wdata = wr_word_sw;
      default: dev_wdata = {{(DATA_W-8){1'b0}}, host_wdata[7:0]};
    endcase

    if (is_write) begin
      host_rdata = '0;
    end else if (tgt == TGT_NONE) begin
      unique case (acc_size_e'(size))
        SZ_BYTE: host_rdata = {{(DATA_W-8){1'b0}}, 8'hFF};
        SZ_HALF: host_rdata = {{(DATA_W-16){1'b0}}, 16'hFFFF};
        default: host_rdata = '1;
      endcase
    end else if (tgt == TGT_DATA) begin
      host_rdata = (acc_size_e'(size) == SZ_HALF) ? rd_half_sw : rd_word_sw;
    end else begin
      host_rdata = {{(DATA_W-8){1'b0}}, dev_rdata[7:0]};
    end
  end

endmodule

// File: rtl/idewin_resp.sv
module idewin_resp #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [DATA_W-1:0] rdata_next,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= accept;
      if (accept) rsp_rdata <= rdata_next;
    end
  end

  AST_ACK_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rsp_valid); // R9
  AST_NO_SPURIOUS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> !rsp_valid); // R9
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(rsp_rdata)); // R10

endmodule

// File: rtl/idewin_bridge.sv
module idewin_bridge
  import idewin_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int WIN_BITS    = 12,
  parameter int STRIDE_BITS = 4,
  parameter int CTRL_IDX_A  = 8,
  parameter int CTRL_IDX_B  = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              dn_rd,
  output logic              dn_wr,
  output logic [1:0]        dn_sel,
  output logic [2:0]        dn_idx,
  output logic [1:0]        dn_size,
  output logic [DATA_W-1:0] dn_wdata,
  input  logic [DATA_W-1:0] dn_rdata
);
  route_t            route;
  logic              accept;
  logic              mapped;
  logic [DATA_W-1:0] rdata_next;

  idewin_decode #(
    .ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS), .STRIDE_BITS(STRIDE_BITS),
    .TF_FIRST(1), .TF_LAST(7),
    .CTRL_IDX_A(CTRL_IDX_A), .CTRL_IDX_B(CTRL_IDX_B), .DATA_IDX(0)
  ) u_decode (
    .addr (req_addr),
    .size (req_size),
    .route(route)
  );

  idewin_lanes #(.DATA_W(DATA_W)) u_lanes (
    .size      (req_size),
    .tgt       (route.tgt),
    .is_write  (req_write),
    .host_wdata(req_wdata),
    .dev_rdata (dn_rdata),
    .dev_wdata (dn_wdata),
    .host_rdata(rdata_next)
  );

  idewin_resp #(.DATA_W(DATA_W)) u_resp (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .rdata_next(rdata_next),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );

  always_comb begin
    req_ready = !rsp_valid;
    accept    = req_valid && req_ready;
    mapped    = (route.tgt != TGT_NONE);
    dn_rd     = accept && mapped && !req_write;
    dn_wr     = accept && mapped && req_write;
    dn_sel    = route.tgt;
    dn_idx    = route.reg_no;
    dn_size   = req_size;
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dn_rd, dn_wr})); // R11
  AST_STROBE_NEEDS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_rd || dn_wr) |-> (req_valid && !rsp_valid)); // R11
  AST_DATA_NEVER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    ((dn_rd || dn_wr) && dn_sel == 2'd2) |-> (dn_size == 2'd1 || dn_size == 2'd2)); // R5
  AST_WORD_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !req_write && !dn_rd && req_size == 2'd2) |=> (rsp_rdata == '1)); // R6
  AST_BYTE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !req_write && !dn_rd && req_size == 2'd0) |=> (rsp_rdata == 32'h0000_00FF)); // R4

endmodule

// File: tb/idewin_bridge_tb.sv
module idewin_bridge_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [31:0] req_addr, req_wdata;
  logic [1:0]  req_size;
  logic        req_ready, rsp_valid;
  logic [31:0] rsp_rdata;
  logic        dn_rd, dn_wr;
  logic [1:0]  dn_sel, dn_size;
  logic [2:0]  dn_idx;
  logic [31:0] dn_wdata, dn_rdata;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  function automatic logic [31:0] dev_val(input logic [1:0] s, input logic [2:0] i);
    return 32'h8421_7A3C ^ ({27'h0, s, i} * 32'h0103_0507);
  endfunction

  assign dn_rdata = dev_val(dn_sel, dn_idx);

  idewin_bridge u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .dn_rd(dn_rd), .dn_wr(dn_wr), .dn_sel(dn_sel), .dn_idx(dn_idx),
    .dn_size(dn_size), .dn_wdata(dn_wdata), .dn_rdata(dn_rdata)
  );

  function automatic logic [31:0] sw16(input logic [31:0] v);
    return {16'h0, v[7:0], v[15:8]};
  endfunction
  function automatic logic [31:0] sw32(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  // returns {mapped, sel[1:0], idx[2:0]}
  function automatic logic [5:0] exp_route(input logic [31:0] a, input logic [1:0] sz);
    logic [7:0] ix;
    ix = a[11:4];
    if (sz == 2'd0) begin
      if (ix >= 8'd1 && ix <= 8'd7) return {1'b1, 2'd0, ix[2:0]};
      if (ix == 8'd8 || ix == 8'd22) return {1'b1, 2'd1, 3'd0};
      return 6'b0;
    end
    if ((sz == 2'd1 || sz == 2'd2) && ix == 8'd0) return {1'b1, 2'd2, 3'd0};
    return 6'b0;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic access(input bit wr, input logic [31:0] a, input logic [1:0] sz,
                        input logic [31:0] wd, input string tag);
    logic [5:0]  rt;
    logic [31:0] exp_rd, exp_wd, held;
    rt = exp_route(a, sz);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz; req_wdata = wd;
    #1;
    chk(req_ready == 1'b1, "R9", "ready before access", {31'h0, req_ready}, 32'h1);
    chk(dn_rd == (rt[5] && !wr) && dn_wr == (rt[5] && wr), tag, "strobes R11",
        {30'h0, dn_rd, dn_wr}, {30'h0, rt[5] && !wr, rt[5] && wr});
    if (rt[5]) begin
      chk(dn_sel == rt[4:3] && dn_idx == rt[2:0] && dn_size == sz, tag, "routing",
          {25'h0, dn_sel, dn_idx, dn_size}, {25'h0, rt[4:3], rt[2:0], sz});
      if (wr) begin
        exp_wd = (sz == 2'd1) ? sw16(wd) : (sz == 2'd2) ? sw32(wd) : {24'h0, wd[7:0]};
        chk(dn_wdata == exp_wd, tag, "write lanes", dn_wdata, exp_wd);
      end
    end
    if (wr) exp_rd = 32'h0;
    else if (!rt[5]) exp_rd = (sz == 2'd0) ? 32'hFF : (sz == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
    else if (sz == 2'd1) exp_rd = sw16(dev_val(rt[4:3], rt[2:0]));
    else if (sz == 2'd2) exp_rd = sw32(dev_val(rt[4:3], rt[2:0]));
    else exp_rd = {24'h0, dev_val(rt[4:3], rt[2:0]) & 32'hFF};
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid == 1'b1 && req_ready == 1'b0, "R9", "ack one cycle later",
        {30'h0, rsp_valid, req_ready}, 32'h2);
    chk(rsp_rdata == exp_rd, tag, "response data R10", rsp_rdata, exp_rd);
    held = rsp_rdata;
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R9", "ack lasts one cycle", {31'h0, rsp_valid}, 32'h0);
    chk(rsp_rdata == held, "R10", "data held", rsp_rdata, held);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] seed_dummy;
    req_valid = 0; req_write = 0; req_addr = 0; req_size = 0; req_wdata = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk(rsp_valid == 0 && rsp_rdata == 0 && dn_rd == 0 && dn_wr == 0, "R9", "reset state",
        {rsp_valid, rsp_rdata[30:0]}, 32'h0);
    rst_n = 1;
    seed_dummy = $urandom(32'd1234);

    // R2 task-file bytes, with upper and lower address bits set (R1)
    access(0, 32'hABCD_E013, 2'd0, 32'h0, "R2");
    access(1, 32'h0000_0070, 2'd0, 32'hDEAD_BE5A, "R2");
    access(0, 32'h1234_5075, 2'd0, 32'h0, "R1");
    // R3 control aliases
    access(1, 32'h0000_0080, 2'd0, 32'h0000_0006, "R3");
    access(0, 32'hFFFF_F160, 2'd0, 32'h0, "R3");
    access(0, 32'h0000_008F, 2'd0, 32'h0, "R3");
    // R4 unmapped bytes, index 0 included
    access(0, 32'h0000_0000, 2'd0, 32'h0, "R4");
    access(1, 32'h0000_0003, 2'd0, 32'h11, "R4");
    access(0, 32'h0000_0090, 2'd0, 32'h0, "R4");
    access(0, 32'h0000_0170, 2'd0, 32'h0, "R4");
    // R5/R7/R8 data port
    access(1, 32'h0000_0000, 2'd1, 32'hFFFF_1234, "R7");
    access(0, 32'h7000_000E, 2'd1, 32'h0, "R7");
    access(1, 32'h0000_0004, 2'd2, 32'h0102_0304, "R8");
    access(0, 32'h0000_0000, 2'd2, 32'h0, "R8");
    // R6 wide accesses off the data port
    access(0, 32'h0000_0010, 2'd1, 32'h0, "R6");
    access(0, 32'h0000_0FF0, 2'd2, 32'h0, "R6");
    access(1, 32'h0000_0080, 2'd2, 32'h5555_AAAA, "R6");
    // R12 reserved size
    access(0, 32'h0000_0000, 2'd3, 32'h0, "R12");
    access(1, 32'h0000_0010, 2'd3, 32'h77, "R12");

    for (int n = 0; n < 400; n++) begin
      logic [7:0]  ix;
      logic [31:0] a;
      case ($urandom_range(0, 9))
        0: ix = 8'd0;   1: ix = 8'd1;   2: ix = 8'd7;   3: ix = 8'd8;
        4: ix = 8'd9;   5: ix = 8'd21;  6: ix = 8'd22;  7: ix = 8'd23;
        8: ix = 8'd255; default: ix = 8'($urandom);
      endcase
      a = {20'($urandom), ix, 4'($urandom)};
      access(1'($urandom), a, 2'($urandom), $urandom, "R1");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule